// File: doc/BRIEF.md
# Bank-Aware Memory Request Reorderer

This block sits in front of a DRAM command scheduler and collects read and write requests from several clients in a small window. Every cycle it offers one of the buffered requests to the scheduler. Its choice is meant to keep the scheduler working on rows that are already open. Changing the row of a bank means closing the open row and activating another one, which costs time, so the block avoids it when it can.

The block keeps a table with one open row for each bank. Whenever a request is issued, the table records that request's row as the open row of its bank. Each pending request is then sorted into one of three classes: it hits the open row, it targets a bank with no open row, or it conflicts with the open row.

Two rules limit how long a request can be held back by this grouping. A client can mark a request as urgent. A request that has waited for at least the programmable age limit moves ahead of everything else. Two requests to the same address always leave in the order they arrived.

Top module: `mem_req_reorder`

## Requirements
- R1: The buffer holds DEPTH (default 8) requests. When it is full, `in_ready` is low and a request offered on `in_valid` is not stored: it never appears on the output.
- R2: After reset, `out_valid` is 0 and `in_ready` is 1. Whenever at least one request is buffered, `out_valid` is 1.
- R3: A request is issued in a cycle where `out_valid` and `out_ready` are both 1. After it issues, its row becomes the open row of its bank. `out_kind` gives the class of the offered request against the table as it stood before the issue: 0 means the row is open (hit), 1 means the bank has no open row (closed), and 2 means a different row is open (conflict). After reset, no bank has an open row.
- R4: Among requests that are neither aged nor urgent, a hit is chosen before a closed-bank request, and a closed-bank request is chosen before a conflict.
- R5: An urgent request is chosen before any request that is not urgent, whatever its locality class, unless an aged request is pending.
- R6: Each request's age starts at 0 when it is accepted and grows by 1 for every clock edge it spends waiting, stopping at its maximum value. A request whose age is at least `age_limit` is chosen before every request that is not aged, urgent ones included.
- R7: When requests have equal priority, the one that arrived first is chosen.
- R8: A request is never issued ahead of an older pending request that has the same bank, row and column, even if the younger request is urgent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| age_limit | input | AGE_W | Age at which a request counts as aged |
| in_valid | input | 1 | Client offers a request |
| in_ready | output | 1 | Buffer has a free slot |
| in_write | input | 1 | 1 for a write, 0 for a read |
| in_urgent | input | 1 | Request is latency-critical |
| in_bank | input | BANK_W | Target bank |
| in_row | input | ROW_W | Target row |
| in_col | input | COL_W | Target column |
| in_tag | input | TAG_W | Client identifier, returned with the request |
| out_valid | output | 1 | A request is offered to the scheduler |
| out_ready | input | 1 | Scheduler takes the offered request |
| out_write | output | 1 | Write flag of the offered request |
| out_bank | output | BANK_W | Bank of the offered request |
| out_row | output | ROW_W | Row of the offered request |
| out_col | output | COL_W | Column of the offered request |
| out_tag | output | TAG_W | Tag of the offered request |
| out_kind | output | 2 | Locality class: 0 hit, 1 closed, 2 conflict |

## Verification
Some properties are checked on every cycle by assertions. The occupancy never goes past the depth, and no request is accepted while the buffer is full. An issued row is recorded as the open row of its bank. A non-empty buffer always offers a request. When an aged request is pending, the chosen request is aged. When an urgent request is pending and none is aged, the chosen request is urgent. Other behaviour can only be shown by the bench's scenarios, because it depends on a history of requests: the full issue order across all three locality classes, the oldest-first tie break, holding back a same-address request behind an older one, the age limit taking over from urgency after a measured wait, and the class of a single request for every bank and row in a sweep.

// File: rtl/mrr_pkg.sv
package mrr_pkg;

  typedef enum logic [1:0] {
    KIND_HIT      = 2'd0,
    KIND_CLOSED   = 2'd1,
    KIND_CONFLICT = 2'd2
  } row_kind_e;

  // Locality rank used in selection: hit > closed > conflict.
  function automatic logic [1:0] locality_rank(row_kind_e k);
    case (k)
      KIND_HIT:    return 2'd2;
      KIND_CLOSED: return 2'd1;
      default:     return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/mrr_queue.sv
module mrr_queue #(
  parameter int DEPTH  = 8,
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14,
  parameter int COL_W  = 10,
  parameter int TAG_W  = 4,
  parameter int AGE_W  = 6,
  parameter int IDX_W  = 3,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              push_write,
  input  logic              push_urgent,
  input  logic [BANK_W-1:0] push_bank,
  input  logic [ROW_W-1:0]  push_row,
  input  logic [COL_W-1:0]  push_col,
  input  logic [TAG_W-1:0]  push_tag,
  input  logic              pop,
  input  logic [IDX_W-1:0]  pop_idx,
  output logic [CNT_W-1:0]  count,
  output logic [DEPTH-1:0]  e_valid,
  output logic              e_write  [DEPTH],
  output logic              e_urgent [DEPTH],
  output logic [BANK_W-1:0] e_bank   [DEPTH],
  output logic [ROW_W-1:0]  e_row    [DEPTH],
  output logic [COL_W-1:0]  e_col    [DEPTH],
  output logic [TAG_W-1:0]  e_tag    [DEPTH],
  output logic [AGE_W-1:0]  e_age    [DEPTH]
);

  logic              n_write  [DEPTH];
  logic              n_urgent [DEPTH];
  logic [BANK_W-1:0] n_bank   [DEPTH];
  logic [ROW_W-1:0]  n_row    [DEPTH];
  logic [COL_W-1:0]  n_col    [DEPTH];
  logic [TAG_W-1:0]  n_tag    [DEPTH];
  logic [AGE_W-1:0]  n_age    [DEPTH];
  logic [CNT_W-1:0]  count_n;
  logic [CNT_W-1:0]  cnt_after_pop;
  logic              adv;

  function automatic logic [AGE_W-1:0] age_inc(logic [AGE_W-1:0] a);
    return (a == '1) ? a : a + 1'b1;
  endfunction

  // Next state: close the gap left by the popped entry, then append.
  always_comb begin
    int src;
    cnt_after_pop = count - CNT_W'(pop);
    count_n       = cnt_after_pop + CNT_W'(push);
    adv           = push | pop | (count != '0);
    for (int i = 0; i < DEPTH; i++) begin
      src = (pop && (i >= int'(pop_idx)) && (i < DEPTH - 1)) ? i + 1 : i;
      n_write[i]  = e_write[src];
      n_urgent[i] = e_urgent[src];
      n_bank[i]   = e_bank[src];
      n_row[i]    = e_row[src];
      n_col[i]    = e_col[src];
      n_tag[i]    = e_tag[src];
      n_age[i]    = age_inc(e_age[src]);
      if (push && (int'(cnt_after_pop) == i)) begin
        n_write[i]  = push_write;
        n_urgent[i] = push_urgent;
        n_bank[i]   = push_bank;
        n_row[i]    = push_row;
        n_col[i]    = push_col;
        n_tag[i]    = push_tag;
        n_age[i]    = '0;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      e_valid[i] = (int'(count) > i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (adv) begin
      count <= count_n;
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      e_write  <= n_write;
      e_urgent <= n_urgent;
      e_bank   <= n_bank;
      e_row    <= n_row;
      e_col    <= n_col;
      e_tag    <= n_tag;
      e_age    <= n_age;
    end
  end

  // R1
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= DEPTH);

  // R1
  no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(count) == DEPTH) |-> !push);

  // R1
  push_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> (count == $past(count) + 1'b1));

endmodule

// File: rtl/mrr_bank_table.sv
module mrr_bank_table #(
  parameter int NBANK  = 8,
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic [BANK_W-1:0] upd_bank,
  input  logic [ROW_W-1:0]  upd_row,
  output logic [NBANK-1:0]  open_vld,
  output logic [ROW_W-1:0]  open_row [NBANK]
);

  logic [NBANK-1:0] open_vld_n;
  logic [NBANK-1:0] row_we;

  always_comb begin
    for (int b = 0; b < NBANK; b++) begin
      row_we[b] = upd && (int'(upd_bank) == b);
    end
    open_vld_n = open_vld | row_we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_vld <= '0;
    end else if (upd) begin
      open_vld <= open_vld_n;
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_row
    always_ff @(posedge clk) begin
      if (row_we[b]) begin
        open_row[b] <= upd_row;
      end
    end
  end

  // R3
  open_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (open_vld[$past(upd_bank)] && (open_row[$past(upd_bank)] == $past(upd_row))));

endmodule

// File: rtl/mrr_picker.sv
module mrr_picker
  import mrr_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int NBANK  = 8,
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14,
  parameter int COL_W  = 10,
  parameter int AGE_W  = 6,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AGE_W-1:0]  age_limit,
  input  logic [DEPTH-1:0]  e_valid,
  input  logic              e_urgent [DEPTH],
  input  logic [BANK_W-1:0] e_bank   [DEPTH],
  input  logic [ROW_W-1:0]  e_row    [DEPTH],
  input  logic [COL_W-1:0]  e_col    [DEPTH],
  input  logic [AGE_W-1:0]  e_age    [DEPTH],
  input  logic [NBANK-1:0]  open_vld,
  input  logic [ROW_W-1:0]  open_row [NBANK],
  output logic              any_valid,
  output logic [IDX_W-1:0]  sel_idx,
  output row_kind_e         sel_kind
);

  row_kind_e        kind  [DEPTH];
  logic [3:0]       score [DEPTH];
  logic [DEPTH-1:0] blocked;
  logic [DEPTH-1:0] elig;
  logic [DEPTH-1:0] aged;
  logic [3:0]       best;

  // Classify each entry against the open-row table.
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      if (!open_vld[e_bank[i]]) begin
        kind[i] = KIND_CLOSED;
      end else if (open_row[e_bank[i]] == e_row[i]) begin
        kind[i] = KIND_HIT;
      end else begin
        kind[i] = KIND_CONFLICT;
      end
    end
  end

  // Same-address ordering: an older pending match blocks the entry.
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      blocked[i] = 1'b0;
      for (int j = 0; j < i; j++) begin
        if (e_valid[j] && (e_bank[j] == e_bank[i]) &&
            (e_row[j] == e_row[i]) && (e_col[j] == e_col[i])) begin
          blocked[i] = 1'b1;
        end
      end
      elig[i]  = e_valid[i] && !blocked[i];
      aged[i]  = (e_age[i] >= age_limit);
      score[i] = {aged[i], e_urgent[i], locality_rank(kind[i])};
    end
  end

  // Highest score wins; the lowest index (oldest) wins a tie.
  always_comb begin
    any_valid = 1'b0;
    best      = '0;
    sel_idx   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (elig[i] && (!any_valid || (score[i] > best))) begin
        any_valid = 1'b1;
        best      = score[i];
        sel_idx   = IDX_W'(i);
      end
    end
    sel_kind = kind[sel_idx];
  end

  logic any_aged_elig;
  logic any_urgent_elig;
  always_comb begin
    any_aged_elig   = |(elig & aged);
    any_urgent_elig = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (elig[i] && e_urgent[i]) any_urgent_elig = 1'b1;
    end
  end

  // R2
  head_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    e_valid[0] |-> any_valid);

  // R6
  aged_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_aged_elig |-> (e_age[sel_idx] >= age_limit));

  // R5
  urgent_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_aged_elig && any_urgent_elig) |-> e_urgent[sel_idx]);

endmodule

// File: rtl/mem_req_reorder.sv
module mem_req_reorder
  import mrr_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int NBANK = 8,
  parameter int ROW_W = 14,
  parameter int COL_W = 10,
  parameter int TAG_W = 4,
  parameter int AGE_W = 6,
  localparam int BANK_W = $clog2(NBANK),
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AGE_W-1:0]  age_limit,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_write,
  input  logic              in_urgent,
  input  logic [BANK_W-1:0] in_bank,
  input  logic [ROW_W-1:0]  in_row,
  input  logic [COL_W-1:0]  in_col,
  input  logic [TAG_W-1:0]  in_tag,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_write,
  output logic [BANK_W-1:0] out_bank,
  output logic [ROW_W-1:0]  out_row,
  output logic [COL_W-1:0]  out_col,
  output logic [TAG_W-1:0]  out_tag,
  output logic [1:0]        out_kind
);

  logic [CNT_W-1:0]  count;
  logic [DEPTH-1:0]  e_valid;
  logic              e_write  [DEPTH];
  logic              e_urgent [DEPTH];
  logic [BANK_W-1:0] e_bank   [DEPTH];
  logic [ROW_W-1:0]  e_row    [DEPTH];
  logic [COL_W-1:0]  e_col    [DEPTH];
  logic [TAG_W-1:0]  e_tag    [DEPTH];
  logic [AGE_W-1:0]  e_age    [DEPTH];
  logic [NBANK-1:0]  open_vld;
  logic [ROW_W-1:0]  open_row [NBANK];
  logic [IDX_W-1:0]  sel_idx;
  row_kind_e         sel_kind;
  logic              any_valid;
  logic              push;
  logic              issue;

  assign in_ready = (int'(count) != DEPTH);
  assign push     = in_valid && in_ready;
  assign issue    = any_valid && out_ready;

  mrr_queue #(
    .DEPTH(DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W),
    .TAG_W(TAG_W), .AGE_W(AGE_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_queue (
    .clk(clk), .rst_n(rst_n),
    .push(push), .push_write(in_write), .push_urgent(in_urgent),
    .push_bank(in_bank), .push_row(in_row), .push_col(in_col), .push_tag(in_tag),
    .pop(issue), .pop_idx(sel_idx),
    .count(count), .e_valid(e_valid), .e_write(e_write), .e_urgent(e_urgent),
    .e_bank(e_bank), .e_row(e_row), .e_col(e_col), .e_tag(e_tag), .e_age(e_age)
  );

  mrr_bank_table #(
    .NBANK(NBANK), .BANK_W(BANK_W), .ROW_W(ROW_W)
  ) u_banks (
    .clk(clk), .rst_n(rst_n),
    .upd(issue), .upd_bank(e_bank[sel_idx]), .upd_row(e_row[sel_idx]),
    .open_vld(open_vld), .open_row(open_row)
  );

  mrr_picker #(
    .DEPTH(DEPTH), .NBANK(NBANK), .BANK_W(BANK_W), .ROW_W(ROW_W),
    .COL_W(COL_W), .AGE_W(AGE_W), .IDX_W(IDX_W)
  ) u_pick (
    .clk(clk), .rst_n(rst_n), .age_limit(age_limit),
    .e_valid(e_valid), .e_urgent(e_urgent), .e_bank(e_bank), .e_row(e_row),
    .e_col(e_col), .e_age(e_age), .open_vld(open_vld), .open_row(open_row),
    .any_valid(any_valid), .sel_idx(sel_idx), .sel_kind(sel_kind)
  );

  assign out_valid = any_valid;
  assign out_write = e_write[sel_idx];
  assign out_bank  = e_bank[sel_idx];
  assign out_row   = e_row[sel_idx];
  assign out_col   = e_col[sel_idx];
  assign out_tag   = e_tag[sel_idx];
  assign out_kind  = sel_kind;

endmodule

// File: tb/mem_req_reorder_test.sv
module mem_req_reorder_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  age_limit;
  logic        in_valid, in_ready, in_write, in_urgent;
  logic [2:0]  in_bank;
  logic [13:0] in_row;
  logic [9:0]  in_col;
  logic [3:0]  in_tag;
  logic        out_valid, out_ready, out_write;
  logic [2:0]  out_bank;
  logic [13:0] out_row;
  logic [9:0]  out_col;
  logic [3:0]  out_tag;
  logic [1:0]  out_kind;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  bit m_open [8];
  int m_row  [8];

  always #5 clk = ~clk;

  mem_req_reorder uut (
    .clk(clk), .rst_n(rst_n), .age_limit(age_limit),
    .in_valid(in_valid), .in_ready(in_ready), .in_write(in_write),
    .in_urgent(in_urgent), .in_bank(in_bank), .in_row(in_row),
    .in_col(in_col), .in_tag(in_tag),
    .out_valid(out_valid), .out_ready(out_ready), .out_write(out_write),
    .out_bank(out_bank), .out_row(out_row), .out_col(out_col),
    .out_tag(out_tag), .out_kind(out_kind)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Called at a negedge; the request is stored at the next posedge.
  task automatic push(bit wr, bit urg, int bank, int row, int col, int tag);
    in_valid  = 1'b1;
    in_write  = wr;
    in_urgent = urg;
    in_bank   = 3'(bank);
    in_row    = 14'(row);
    in_col    = 10'(col);
    in_tag    = 4'(tag);
    @(negedge clk);
    in_valid  = 1'b0;
    in_urgent = 1'b0;
  endtask

  // Check the offered request, then take it over one edge.
  task automatic take(string req, int tag, int bank, int row, bit wr);
    int exp_kind;
    if (!m_open[bank]) exp_kind = 1;
    else if (m_row[bank] == row) exp_kind = 0;
    else exp_kind = 2;
    check(req, "out_valid", int'(out_valid), 1);
    check(req, "out_tag", int'(out_tag), tag);
    check(req, "out_kind", int'(out_kind), exp_kind);
    check(req, "out_write", int'(out_write), int'(wr));
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    m_open[bank] = 1'b1;
    m_row[bank]  = row;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < 8; b++) begin m_open[b] = 1'b0; m_row[b] = 0; end
    rst_n = 1'b0; age_limit = 6'd63;
    in_valid = 0; in_write = 0; in_urgent = 0;
    in_bank = 0; in_row = 0; in_col = 0; in_tag = 0; out_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 reset state
    check("R2", "out_valid after reset", int'(out_valid), 0);
    check("R2", "in_ready after reset", int'(in_ready), 1);

    // R4 R7: all banks closed, oldest first, then the hit it opens
    push(0, 0, 0, 1, 0, 1);
    check("R2", "out_valid nonempty", int'(out_valid), 1);
    push(0, 0, 1, 2, 0, 2);
    push(1, 0, 0, 1, 1, 3);
    take("R7", 1, 0, 1, 0);
    take("R4", 3, 0, 1, 1);
    take("R4", 2, 1, 2, 0);

    // R4: hit, then closed, then conflict
    push(0, 0, 0, 5, 0, 4);
    push(0, 0, 2, 0, 0, 5);
    push(0, 0, 1, 2, 3, 6);
    take("R4", 6, 1, 2, 0);
    take("R4", 5, 2, 0, 0);
    take("R4", 4, 0, 5, 0);

    // R5: urgent closed-bank request beats a hit
    push(0, 0, 0, 5, 1, 7);
    push(0, 1, 3, 0, 0, 8);
    take("R5", 8, 3, 0, 0);
    take("R5", 7, 0, 5, 0);

    // R8: younger urgent read to the same address waits for the write
    push(1, 0, 5, 1, 2, 9);
    push(0, 1, 5, 1, 2, 10);
    push(0, 0, 6, 0, 0, 11);
    take("R8", 9, 5, 1, 1);
    take("R8", 10, 5, 1, 0);
    take("R8", 11, 6, 0, 0);

    // R6: aged conflict beats a fresh urgent hit
    age_limit = 6'd2;
    push(0, 0, 0, 6, 0, 12);
    repeat (3) @(negedge clk);
    push(0, 1, 1, 2, 0, 13);
    take("R6", 12, 0, 6, 0);
    take("R6", 13, 1, 2, 0);
    age_limit = 6'd63;

    // R1: fill, refuse one more, drain in arrival order (R7)
    for (int k = 0; k < 8; k++) push(0, 0, 7, k, 0, k);
    check("R1", "in_ready when full", int'(in_ready), 0);
    push(1, 1, 4, 0, 0, 15);
    for (int k = 0; k < 8; k++) take("R7", k, 7, k, 0);
    check("R1", "rejected request absent", int'(out_valid), 0);
    check("R1", "in_ready after drain", int'(in_ready), 1);

    // R3: sweep every bank over four rows, class from the bench table
    for (int b = 0; b < 8; b++) begin
      for (int r = 0; r < 4; r++) begin
        push(r[0], 0, b, r * 3, r, (b * 4 + r) % 16);
        take("R3", (b * 4 + r) % 16, b, r * 3, r[0]);
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule